// File: doc/BRIEF.md
# Multi-Channel Match PWM Generator

This block produces six pulse-width-modulated outputs from one counter. The counter advances on each clock-enable tick and is compared with a bank of seven match values. Match value 0 closes the period: when the counter reaches it and its reset action is enabled, the counter returns to zero. Every output shares that one repetition rate. Period and pulse width are both whole tick counts, so resolution can be traded against repetition rate. The block has no fixed resolution of its own.

Each output runs in one of two modes. In single-edge mode, output j rises at the start of every period and falls when the counter matches value j. In double-edge mode, even output j rises on match j-1 and falls on match j. The order of the two values decides whether the pulse is positive-going or negative-going.

Every match value carries three actions that can be enabled on their own: raise a sticky interrupt flag, reset the counter, or stop the counter. Software writes new match values into shadow copies. These copies reach the comparators only when a period restarts, so a pulse is never cut short partway through a period.

Top module: `pwm_match_bank`

## Requirements
- R1: After reset the counter is 0, the counter is stopped, and all outputs, flags and the interrupt line are 0. The counter changes only on a cycle where `tick` is 1 and the counter is running, or on a control write.
- R2: When the counter equals active match 0 on an advancing tick and the reset action of match 0 is enabled, the counter becomes 0 on the next cycle. The period is therefore match 0 plus one ticks.
- R3: A write to address k (0..6) changes only the shadow copy of match k. Shadow values are copied into the active values on a period restart (R2) or a control clear (R12), and at no other time.
- R4: In single-edge mode, output j (pwm_out bit j-1) is driven to 1 at a period restart or clear. It returns to 0 on the tick where the counter equals active match j. It is therefore high while the counter shows 0 through match j.
- R5: A single-edge output whose newly loaded match value is 0 is driven low at the period restart, so it stays constantly low.
- R6: In double-edge mode, even output j is set on a match of value j-1 and cleared on a match of value j. With set below clear, the pulse is positive-going.
- R7: With the clear value below the set value, the double-edge output gives a negative-going pulse: it is low only while the counter lies between the two values.
- R8: When the set and the clear for one output fall on the same tick, the clear wins and the output stays 0.
- R9: Action register of match k is at address 7+k. Bit 0 enables the interrupt action, bit 1 the reset action and bit 2 the stop action. A match with bit 0 set raises flag k, and the flag stays set. Writing a 1 to bit k at address 15 clears flag k; a set in the same cycle wins over the clear. `irq` is the OR of the flags whose interrupt enable is set.
- R10: A match with its stop action enabled halts the counter and holds the counter value and all outputs until a control write sets the run bit again.
- R11: A reset action on any match other than 0 returns the counter to 0. It does not copy the shadow values and does not restart the single-edge outputs.
- R12: The control register is at address 14. Bit 0 is run, bit 1 is clear, and bits 4:2 put outputs 2, 4 and 6 into double-edge mode. Clear sets the counter to 0, loads the shadow values, and restarts the single-edge outputs as R4 and R5 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 6 | PWM outputs; bit j-1 is output j |
| irq | output | 1 | Interrupt line |
| cnt_value | output | 16 | Current counter value |
| match_flags | output | 7 | Sticky match flags, bit k for match k |

## Verification
A scoreboard runs a cycle-by-cycle reference model next to the design and compares the counter, outputs, flags and interrupt line on every tick. The first pattern uses only single-edge outputs. Its match values lie below, at zero, and above the period, which separates normal duty cycles from constant-low and constant-high outputs. A second pattern switches the even outputs into double-edge mode with set below clear, clear below set, and both equal. This tells positive pulses from negative pulses and checks that the clear wins on a tie. Further runs use a gapped tick pattern, a mid-period shadow write, interrupt flag set and clear, a stop with restart, and a reset taken from a non-period match. Each one separates counter gating, update timing and action handling.

// File: rtl/pwm_match_pkg.sv
package pwm_match_pkg;
  typedef struct packed {
    logic stop;
    logic rst;
    logic irq;
  } match_act_t;
endpackage

// File: rtl/pwm_match_regs.sv
module pwm_match_regs
  import pwm_match_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 16,
  parameter int NUM_MATCH = 7,
  parameter int NUM_DBL   = 3,
  parameter int ADDR_W    = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic                                  load_cycle,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]       act_q,
  output logic [NUM_MATCH-2:0]                  shadow_nz,
  output match_act_t [NUM_MATCH-1:0]            action_q,
  output logic [NUM_DBL-1:0]                    dbl_mode_q,
  output logic                                  ctl_wr,
  output logic                                  ctl_run,
  output logic                                  ctl_clear,
  output logic [NUM_MATCH-1:0]                  flag_clr
);
  localparam int ACT_BASE = NUM_MATCH;
  localparam int CTL_ADDR = 2 * NUM_MATCH;
  localparam int CLR_ADDR = 2 * NUM_MATCH + 1;

  logic [NUM_MATCH-1:0][CNT_W-1:0] shadow_q, shadow_d, act_d;
  match_act_t [NUM_MATCH-1:0]      action_d;
  logic [NUM_DBL-1:0]              dbl_mode_d;
  logic                            load;

  assign ctl_wr    = wr_en && (int'(wr_addr) == CTL_ADDR);
  assign ctl_run   = wr_data[0];
  assign ctl_clear = ctl_wr && wr_data[1];
  assign flag_clr  = (wr_en && (int'(wr_addr) == CLR_ADDR)) ? wr_data[NUM_MATCH-1:0] : '0;
  assign load      = load_cycle || ctl_clear;

  for (genvar k = 1; k < NUM_MATCH; k++) begin : g_nz
    assign shadow_nz[k-1] = (shadow_q[k] != '0);
  end

  always_comb begin
    shadow_d   = shadow_q;
    action_d   = action_q;
    dbl_mode_d = dbl_mode_q;
    act_d      = load ? shadow_q : act_q;
    for (int k = 0; k < NUM_MATCH; k++) begin
      if (wr_en && (int'(wr_addr) == k)) begin
        shadow_d[k] = wr_data[CNT_W-1:0];
      end
      if (wr_en && (int'(wr_addr) == ACT_BASE + k)) begin
        action_d[k] = match_act_t'(wr_data[2:0]);
      end
    end
    if (ctl_wr) begin
      dbl_mode_d = wr_data[2+NUM_DBL-1:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q   <= '0;
      act_q      <= '0;
      action_q   <= '0;
      dbl_mode_q <= '0;
    end else begin
      shadow_q   <= shadow_d;
      act_q      <= act_d;
      action_q   <= action_d;
      dbl_mode_q <= dbl_mode_d;
    end
  end
endmodule

// File: rtl/pwm_match_counter.sv
module pwm_match_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctl_wr,
  input  logic             ctl_run,
  input  logic             ctl_clear,
  input  logic             rst_hit,
  input  logic             stop_hit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             running_q,
  output logic             adv
);
  logic [CNT_W-1:0] cnt_d;
  logic             running_d;

  assign adv = tick && running_q && !ctl_clear;

  always_comb begin
    cnt_d = cnt_q;
    if (ctl_clear || rst_hit) begin
      cnt_d = '0;
    end else if (stop_hit) begin
      cnt_d = cnt_q;
    end else if (adv) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    running_d = running_q;
    if (ctl_wr) begin
      running_d = ctl_run;
    end else if (stop_hit) begin
      running_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      running_q <= running_d;
    end
  end
endmodule

// File: rtl/pwm_match_cmp.sv
module pwm_match_cmp
  import pwm_match_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_MATCH = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [CNT_W-1:0]                cnt,
  input  logic                            adv,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] act,
  input  match_act_t [NUM_MATCH-1:0]      action,
  input  logic [NUM_MATCH-1:0]            flag_clr,
  output logic [NUM_MATCH-1:0]            hit,
  output logic                            rst_hit,
  output logic                            stop_hit,
  output logic                            cycle_start,
  output logic [NUM_MATCH-1:0]            flags_q,
  output logic                            irq
);
  logic [NUM_MATCH-1:0] irq_en, rst_en, stop_en, flags_d;

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_cmp
    assign hit[k]     = adv && (cnt == act[k]);
    assign irq_en[k]  = action[k].irq;
    assign rst_en[k]  = action[k].rst;
    assign stop_en[k] = action[k].stop;
  end

  assign rst_hit     = |(hit & rst_en);
  assign stop_hit    = |(hit & stop_en);
  assign cycle_start = hit[0] && rst_en[0];
  assign flags_d     = (flags_q & ~flag_clr) | (hit & irq_en);
  assign irq         = |(flags_q & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/pwm_edge_ctrl.sv
module pwm_edge_ctrl #(
  parameter int NUM_OUT = 6,
  parameter int NUM_DBL = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] hit_o,
  input  logic               load,
  input  logic [NUM_OUT-1:0] shadow_nz,
  input  logic [NUM_DBL-1:0] dbl_mode,
  output logic [NUM_OUT-1:0] pwm_q
);
  logic [NUM_OUT-1:0] pwm_d;
  logic [NUM_OUT-1:0] dbl_sel;
  logic [NUM_OUT-1:0] set_src;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    if ((i % 2) == 1) begin : g_even_out
      assign dbl_sel[i] = dbl_mode[i/2];
      assign set_src[i] = hit_o[i-1];
    end else begin : g_odd_out
      assign dbl_sel[i] = 1'b0;
      assign set_src[i] = 1'b0;
    end

    always_comb begin
      pwm_d[i] = pwm_q[i];
      if (dbl_sel[i]) begin
        if (set_src[i]) pwm_d[i] = 1'b1;
      end else if (load) begin
        pwm_d[i] = shadow_nz[i];
      end
      if (hit_o[i]) pwm_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= '0;
    end else begin
      pwm_q <= pwm_d;
    end
  end
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank
  import pwm_match_pkg::*;
#(
  parameter int  CNT_W     = 16,
  parameter int  NUM_OUT   = 6,
  parameter int  DATA_W    = 16,
  localparam int NUM_MATCH = NUM_OUT + 1,
  localparam int NUM_DBL   = NUM_OUT / 2,
  localparam int ADDR_W    = $clog2(2 * NUM_MATCH + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [NUM_OUT-1:0]   pwm_out,
  output logic                 irq,
  output logic [CNT_W-1:0]     cnt_value,
  output logic [NUM_MATCH-1:0] match_flags
);
  logic [NUM_MATCH-1:0][CNT_W-1:0] act_q;
  logic [NUM_OUT-1:0]              shadow_nz;
  match_act_t [NUM_MATCH-1:0]      action_q;
  logic [NUM_DBL-1:0]              dbl_mode;
  logic                            ctl_wr, ctl_run, ctl_clear;
  logic [NUM_MATCH-1:0]            flag_clr, hit;
  logic                            rst_hit, stop_hit, cycle_start;
  logic                            running, adv;

  pwm_match_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_MATCH(NUM_MATCH),
    .NUM_DBL(NUM_DBL), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_cycle(cycle_start), .act_q(act_q),
    .shadow_nz(shadow_nz), .action_q(action_q), .dbl_mode_q(dbl_mode),
    .ctl_wr(ctl_wr), .ctl_run(ctl_run), .ctl_clear(ctl_clear),
    .flag_clr(flag_clr)
  );

  pwm_match_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_wr(ctl_wr),
    .ctl_run(ctl_run), .ctl_clear(ctl_clear), .rst_hit(rst_hit),
    .stop_hit(stop_hit), .cnt_q(cnt_value), .running_q(running), .adv(adv)
  );

  pwm_match_cmp #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_value), .adv(adv), .act(act_q),
    .action(action_q), .flag_clr(flag_clr), .hit(hit), .rst_hit(rst_hit),
    .stop_hit(stop_hit), .cycle_start(cycle_start), .flags_q(match_flags),
    .irq(irq)
  );

  pwm_edge_ctrl #(.NUM_OUT(NUM_OUT), .NUM_DBL(NUM_DBL)) u_edge (
    .clk(clk), .rst_n(rst_n), .hit_o(hit[NUM_MATCH-1:1]),
    .load(cycle_start || ctl_clear), .shadow_nz(shadow_nz),
    .dbl_mode(dbl_mode), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/pwm_match_bank_checker.sv
module pwm_match_bank_checker #(
  parameter int CNT_W     = 16,
  parameter int NUM_OUT   = 6,
  parameter int NUM_MATCH = 7,
  parameter int ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [NUM_OUT-1:0]   pwm_out,
  input logic [CNT_W-1:0]     cnt_value,
  input logic [NUM_MATCH-1:0] match_flags,
  input logic [CNT_W-1:0]     act0,
  input logic [CNT_W-1:0]     act1,
  input logic [CNT_W-1:0]     act2,
  input logic                 rst_en0,
  input logic                 dbl2,
  input logic                 running
);
  localparam int CTL_ADDR = 2 * NUM_MATCH;
  logic ctl_w;
  assign ctl_w = wr_en && (int'(wr_addr) == CTL_ADDR);

  assert_cnt_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctl_w) |=> $stable(cnt_value));

  assert_period_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && !ctl_w && rst_en0 && cnt_value == act0) |=> (cnt_value == '0));

  assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctl_w) |=> ($stable(act0) && $stable(act1) && $stable(act2)));

  assert_zero_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out[0]) |-> (act1 != '0));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && !ctl_w && dbl2 && cnt_value == act2) |=> !pwm_out[1]);

  assert_flags_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(match_flags));

  assert_stop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ctl_w) |=> ($stable(cnt_value) && $stable(pwm_out)));
endmodule

bind pwm_match_bank pwm_match_bank_checker #(
  .CNT_W(CNT_W), .NUM_OUT(NUM_OUT), .NUM_MATCH(NUM_MATCH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .pwm_out(pwm_out), .cnt_value(cnt_value), .match_flags(match_flags),
  .act0(act_q[0]), .act1(act_q[1]), .act2(act_q[2]),
  .rst_en0(action_q[0].rst), .dbl2(dbl_mode[0]), .running(running)
);

// File: tb/pwm_match_bank_bench.sv
module pwm_match_bank_bench;
  logic        clk, rst_n, tick, wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [5:0]  pwm_out;
  logic        irq;
  logic [15:0] cnt_value;
  logic [6:0]  match_flags;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pwm_match_bank u_pwm_match_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq), .cnt_value(cnt_value),
    .match_flags(match_flags)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [15:0] cnt;
    logic [5:0]  pwm;
    logic [6:0]  flags;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference model state
  logic [15:0] m_cnt;
  logic        m_run;
  logic [15:0] m_act[7];
  logic [15:0] m_sh[7];
  logic [2:0]  m_cfg[7];
  logic [2:0]  m_dbl;
  logic [5:0]  m_pwm;
  logic [6:0]  m_flags;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit t, bit we, int addr, int data, string tag);
    logic [6:0] hit, irqen, clr;
    logic ctl_wr, ctl_clr, adv, rsth, stoph, cyc, load;
    logic [5:0] np;
    exp_t e;
    @(negedge clk);
    tick = t; wr_en = we; wr_addr = addr[3:0]; wr_data = data[15:0];
    ctl_wr  = we && addr == 14;
    ctl_clr = ctl_wr && data[1];
    adv     = t && m_run && !ctl_clr;
    rsth = 0; stoph = 0;
    for (int k = 0; k < 7; k++) begin
      hit[k]   = adv && (m_cnt == m_act[k]);
      irqen[k] = m_cfg[k][0];
      if (hit[k] && m_cfg[k][1]) rsth = 1;
      if (hit[k] && m_cfg[k][2]) stoph = 1;
    end
    cyc  = hit[0] && m_cfg[0][1];
    load = cyc || ctl_clr;
    for (int j = 1; j <= 6; j++) begin
      bit dbl;
      dbl = (j % 2 == 0) && m_dbl[j/2-1];
      np[j-1] = m_pwm[j-1];
      if (dbl) begin
        if (hit[j-1]) np[j-1] = 1;
      end else if (load) np[j-1] = (m_sh[j] != 0);
      if (hit[j]) np[j-1] = 0;
    end
    m_pwm = np;
    if (ctl_clr || rsth) m_cnt = 0;
    else if (!stoph && adv) m_cnt = m_cnt + 16'd1;
    if (ctl_wr) m_run = data[0];
    else if (stoph) m_run = 0;
    clr = (we && addr == 15) ? data[6:0] : 7'd0;
    m_flags = (m_flags & ~clr) | (hit & irqen);
    if (load) for (int k = 0; k < 7; k++) m_act[k] = m_sh[k];
    if (we && addr < 7) m_sh[addr] = data[15:0];
    if (we && addr >= 7 && addr < 14) m_cfg[addr-7] = data[2:0];
    if (ctl_wr) m_dbl = data[4:2];
    for (int k = 0; k < 7; k++) irqen[k] = m_cfg[k][0];
    e.cnt = m_cnt; e.pwm = m_pwm; e.flags = m_flags;
    e.irq = |(m_flags & irqen); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wr(int addr, int data, string tag);
    step(1, 1, addr, data, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, tag);
  endtask

  // monitor: compares each expected item one edge after it was queued
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "cnt_value", int'(cnt_value), int'(e.cnt));
        check(e.tag, "pwm_out", int'(pwm_out), int'(e.pwm));
        check(e.tag, "match_flags", int'(match_flags), int'(e.flags));
        check(e.tag, "irq", int'(irq), int'(e.irq));
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    m_cnt = 0; m_run = 0; m_dbl = 0; m_pwm = 0; m_flags = 0;
    for (int k = 0; k < 7; k++) begin
      m_act[k] = 0; m_sh[k] = 0; m_cfg[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1", "reset cnt_value", int'(cnt_value), 0);
    check("R1", "reset pwm_out", int'(pwm_out), 0);
    check("R1", "reset match_flags", int'(match_flags), 0);
    check("R1", "reset irq", int'(irq), 0);
    idle(3, "R1");

    // single-edge setup: period 10, widths below, at zero and beyond the period
    wr(0, 9, "R2");
    wr(7, 2, "R2");
    wr(1, 3, "R4");
    wr(2, 6, "R4");
    wr(3, 0, "R5");
    wr(4, 12, "R4");
    wr(5, 1, "R4");
    wr(6, 8, "R4");
    wr(14, 3, "R12");
    idle(25, "R2/R4/R5");
    // R3: mid-period shadow write takes effect only at the next restart
    wr(1, 5, "R3");
    idle(22, "R3");

    // double-edge: out2 positive, out4 negative, out6 tie
    wr(1, 2, "R6");
    wr(2, 7, "R6");
    wr(3, 7, "R7");
    wr(4, 2, "R7");
    wr(5, 5, "R8");
    wr(6, 5, "R8");
    wr(14, 31, "R12");
    idle(30, "R6/R7/R8");

    // R1: gapped ticks
    for (int i = 0; i < 24; i++) step(i % 3 != 0, 0, 0, 0, "R1");

    // R9: interrupt flags
    wr(8, 1, "R9");
    wr(9, 1, "R9");
    idle(12, "R9");
    wr(15, 2, "R9");
    idle(3, "R9");
    wr(8, 0, "R9");
    idle(5, "R9");
    wr(15, 127, "R9");
    idle(4, "R9");

    // R10: stop on match 6, then restart
    wr(13, 4, "R10");
    idle(15, "R10");
    wr(13, 0, "R10");
    wr(14, 29, "R12");
    idle(12, "R10");

    // R11: reset action on match 5
    wr(12, 2, "R11");
    idle(14, "R11");
    wr(12, 0, "R11");
    idle(14, "R11");

    step(0, 0, 0, 0, "R1");
    repeat (3) @(posedge clk);
    #5;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule